// File: doc/BRIEF.md
# Multi-mode event counter channel

This block is one counter channel of a data-acquisition front end. It counts rising edges on one of several debounced input lines (the main input). A second line from the same group, the auxiliary input, can be given one of three jobs. It can enable counting while it is high, it can count down on its own rising edges, or it can copy the live count into a count register on its rising edges. When the auxiliary input is not used, the channel is a plain up-counter (totalize). In that case the count keeps growing across samples until software or a new acquisition clears it.

The surrounding logic uses the channel in two ways. A scan sequencer asserts `acq_start` once for each new acquisition, which zeroes the count. It then asserts `scan_tick` at the start of every scan, which loads the count register. Software reads through a strobe-and-address port. Reading the low word also captures the full count into a snapshot register, so the matching high word read later belongs to the same instant. That read can optionally clear the live counter. The counter works at full width or at half width, and it either rolls over or stops at its limit.

Top module: `evt_counter_chan`

## Requirements
- R1: After reset the live count, count register, snapshot and `rd_data` are all zero.
- R2: Each rising edge of `cnt_in[main_sel]` raises the count by one, one clock after the edge is presented. A line held high counts once, and the lines that are not selected have no effect.
- R3: `acq_start` clears the live count and the count register to zero, and it overrides any counting edge, read clear or load in the same cycle.
- R4: When `aux_func` is not 3, `scan_tick` copies the live count into the count register. Reads at `rd_addr` 2 and 3 return the low and high word of the count register.
- R5: With `aux_func` = 3 (latch), a rising edge of `cnt_in[aux_sel]` copies the live count into the count register, and `scan_tick` is ignored.
- R6: With `aux_func` = 1 (gate), the counter changes only while `cnt_in[aux_sel]` is high.
- R7: With `aux_func` = 2 (decrement), a rising edge of `cnt_in[aux_sel]` lowers the count by one. An increment and a decrement in the same cycle cancel. With `aux_func` = 0 the auxiliary line is unused.
- R8: A read at `rd_addr` 0 returns the live low word and captures the full count into the snapshot. A read at `rd_addr` 1 returns the high word of that snapshot, not of the live count.
- R9: With `clr_on_read` = 1, a read at `rd_addr` 0 clears the live counter in the same cycle as the snapshot. A counting edge in that same cycle leaves the counter at 1.
- R10: With `limit_mode` = 0 the counter wraps modulo 2^CNT_W when `wide_mode` = 1, or modulo 2^(CNT_W/2) when `wide_mode` = 0 (high word held at zero). A decrement from zero yields the maximum.
- R11: With `limit_mode` = 1 the counter stops at its maximum (all ones at the active width), and a decrement at zero leaves it at zero.
- R12: `rd_data` is registered and shows the selected word one clock after `rd_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_in | input | NIN | Debounced counter input lines |
| main_sel | input | clog2(NIN) | Index of the counted line |
| aux_sel | input | clog2(NIN) | Index of the auxiliary line |
| aux_func | input | 2 | Auxiliary job: 0 none, 1 gate, 2 decrement, 3 latch |
| wide_mode | input | 1 | 1 full width, 0 half width |
| limit_mode | input | 1 | 1 stop at limit, 0 roll over |
| clr_on_read | input | 1 | Clear live count on low-word read |
| acq_start | input | 1 | New acquisition: zero the count |
| scan_tick | input | 1 | Start of scan: load count register |
| rd_stb | input | 1 | Read strobe |
| rd_addr | input | 2 | 0 live low + snapshot, 1 snapshot high, 2/3 count register low/high |
| rd_data | output | CNT_W/2 | Read data word |

## Verification
The bench builds the channel with CNT_W = 8 and the default four inputs, so the half-width limit is 15 and the full-width limit is 255. Both wrap points and both saturation points can then be reached by real edge pulses in a few hundred cycles. The snapshot test uses counts whose high word changes between the low read and the high read, so it can tell a live high word from a captured one.

// File: rtl/evt_counter_chan.sv
module evt_counter_chan #(
  parameter int CNT_W = 32,
  parameter int NIN   = 4,
  localparam int WORD_W = CNT_W / 2,
  localparam int SEL_W  = $clog2(NIN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NIN-1:0]    cnt_in,
  input  logic [SEL_W-1:0]  main_sel,
  input  logic [SEL_W-1:0]  aux_sel,
  input  logic [1:0]        aux_func,
  input  logic              wide_mode,
  input  logic              limit_mode,
  input  logic              clr_on_read,
  input  logic              acq_start,
  input  logic              scan_tick,
  input  logic              rd_stb,
  input  logic [1:0]        rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  localparam logic [1:0] FN_GATE  = 2'd1;
  localparam logic [1:0] FN_DEC   = 2'd2;
  localparam logic [1:0] FN_LATCH = 2'd3;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] HALF = {{(CNT_W-WORD_W){1'b0}}, {WORD_W{1'b1}}};

  logic [NIN-1:0]   in_q, rise_v;
  logic [CNT_W-1:0] cnt, creg, snap, top, base, stepped;
  logic main_rise, aux_rise, aux_lvl, run, up, dn, lo_read, load_creg;

  assign rise_v    = cnt_in & ~in_q;
  assign main_rise = rise_v[main_sel];
  assign aux_rise  = rise_v[aux_sel];
  assign aux_lvl   = cnt_in[aux_sel];
  assign run       = (aux_func != FN_GATE) || aux_lvl;
  assign up        = run && main_rise;
  assign dn        = run && (aux_func == FN_DEC) && aux_rise;
  assign lo_read   = rd_stb && (rd_addr == 2'd0);
  assign top       = wide_mode ? {CNT_W{1'b1}} : HALF;
  assign base      = (lo_read && clr_on_read) ? '0 : (cnt & top);
  assign load_creg = (aux_func == FN_LATCH) ? aux_rise : scan_tick;

  always_comb begin
    stepped = base;
    if (up && !dn) begin
      if (!(limit_mode && base == top)) stepped = (base + ONE) & top;
    end else if (dn && !up) begin
      if (!(limit_mode && base == '0)) stepped = (base - ONE) & top;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q    <= '0;
      cnt     <= '0;
      creg    <= '0;
      snap    <= '0;
      rd_data <= '0;
    end else begin
      in_q <= cnt_in;
      cnt  <= acq_start ? '0 : stepped;
      if (acq_start)      creg <= '0;
      else if (load_creg) creg <= cnt;
      if (lo_read) snap <= cnt;
      if (rd_stb) begin
        case (rd_addr)
          2'd0:    rd_data <= cnt[WORD_W-1:0];
          2'd1:    rd_data <= snap[CNT_W-1:WORD_W];
          2'd2:    rd_data <= creg[WORD_W-1:0];
          default: rd_data <= creg[CNT_W-1:WORD_W];
        endcase
      end
    end
  end
endmodule

// File: rtl/evt_counter_chan_chk.sv
module evt_counter_chan_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acq_start,
  input logic             rd_stb,
  input logic [1:0]       rd_addr,
  input logic             clr_on_read,
  input logic             wide_mode,
  input logic             limit_mode,
  input logic [1:0]       aux_func,
  input logic             aux_lvl,
  input logic             aux_rise,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] creg,
  input logic [CNT_W-1:0] snap
);
  AST_SCAN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    acq_start |=> (cnt == '0) && (creg == '0)); // R3

  AST_SNAP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && rd_addr == 2'd0) |=> snap == $past(cnt)); // R8

  AST_LATCH_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (aux_func == 2'd3 && aux_rise && !acq_start) |=> creg == $past(cnt)); // R5

  AST_GATE_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    (aux_func == 2'd1 && !aux_lvl && wide_mode && !acq_start &&
     !(rd_stb && rd_addr == 2'd0 && clr_on_read)) |=> $stable(cnt)); // R6

  AST_LIMIT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (limit_mode && wide_mode && cnt == {CNT_W{1'b1}} && !acq_start &&
     !(rd_stb && rd_addr == 2'd0 && clr_on_read)) |=> cnt != '0); // R11
endmodule

bind evt_counter_chan evt_counter_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acq_start(acq_start), .rd_stb(rd_stb),
  .rd_addr(rd_addr), .clr_on_read(clr_on_read), .wide_mode(wide_mode),
  .limit_mode(limit_mode), .aux_func(aux_func), .aux_lvl(aux_lvl),
  .aux_rise(aux_rise), .cnt(cnt), .creg(creg), .snap(snap)
);

// File: tb/evt_counter_chan_test.sv
module evt_counter_chan_test;
  localparam int CLK_P = 10;
  localparam int CW = 8;

  logic clk = 0, rst_n = 0;
  logic [3:0] cnt_in = '0;
  logic [1:0] main_sel = '0, aux_sel = '0, aux_func = '0, rd_addr = '0;
  logic wide_mode = 1, limit_mode = 0, clr_on_read = 0;
  logic acq_start = 0, scan_tick = 0, rd_stb = 0;
  logic [3:0] rd_data;
  int checks = 0, fails = 0;
  bit done = 0;

  evt_counter_chan #(.CNT_W(CW), .NIN(4)) uut (
    .clk(clk), .rst_n(rst_n), .cnt_in(cnt_in), .main_sel(main_sel),
    .aux_sel(aux_sel), .aux_func(aux_func), .wide_mode(wide_mode),
    .limit_mode(limit_mode), .clr_on_read(clr_on_read), .acq_start(acq_start),
    .scan_tick(scan_tick), .rd_stb(rd_stb), .rd_addr(rd_addr), .rd_data(rd_data));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulse(logic [3:0] m);
    cnt_in = cnt_in | m;
    @(negedge clk);
    cnt_in = cnt_in & ~m;
    @(negedge clk);
  endtask

  task automatic pulses(logic [3:0] m, int n);
    for (int i = 0; i < n; i++) pulse(m);
  endtask

  task automatic rd(logic [1:0] a, output logic [3:0] d);
    rd_stb = 1; rd_addr = a;
    @(negedge clk);
    rd_stb = 0;
    d = rd_data;
  endtask

  task automatic rd_full(output int v);
    logic [3:0] lo, hi;
    rd(2'd0, lo);
    rd(2'd1, hi);
    v = {hi, lo};
  endtask

  task automatic acq();
    acq_start = 1;
    @(negedge clk);
    acq_start = 0;
  endtask

  task automatic t_reset();
    logic [3:0] d;
    chk("R1 rd_data at reset", rd_data, 0);
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d);
      chk("R1 reset read", d, 0);
    end
  endtask

  task automatic t_count();
    int v;
    main_sel = 2; aux_func = 0; acq();
    pulses(4'b0100, 5);
    pulses(4'b0010, 3);
    pulse(4'b0001);
    cnt_in[2] = 1; repeat (3) @(negedge clk); cnt_in[2] = 0; @(negedge clk);
    rd_full(v);
    chk("R2 edge count", v, 6);
    pulse(4'b1000);
    rd_full(v);
    chk("R7 aux unused in totalize", v, 6);
  endtask

  task automatic t_acq();
    int v; logic [3:0] d;
    scan_tick = 1; @(negedge clk); scan_tick = 0;
    cnt_in[2] = 1; acq_start = 1;
    @(negedge clk);
    cnt_in[2] = 0; acq_start = 0;
    @(negedge clk);
    rd_full(v);
    chk("R3 acq clears over edge", v, 0);
    rd(2'd2, d);
    chk("R3 count register cleared", d, 0);
  endtask

  task automatic t_scan();
    logic [3:0] d;
    pulses(4'b0100, 3);
    scan_tick = 1; @(negedge clk); scan_tick = 0;
    pulses(4'b0100, 2);
    rd(2'd2, d); chk("R4 creg low", d, 3);
    rd(2'd3, d); chk("R4 creg high", d, 0);
  endtask

  task automatic t_latch();
    logic [3:0] d;
    aux_func = 3; aux_sel = 0;
    scan_tick = 1; @(negedge clk); scan_tick = 0;
    rd(2'd2, d); chk("R5 scan_tick ignored in latch", d, 3);
    pulse(4'b0001);
    rd(2'd2, d); chk("R5 aux edge latches", d, 5);
  endtask

  task automatic t_gate();
    int v;
    aux_func = 1; aux_sel = 3; acq();
    pulses(4'b0100, 2);
    rd_full(v); chk("R6 gate closed", v, 0);
    cnt_in[3] = 1;
    pulses(4'b0100, 2);
    cnt_in[3] = 0; @(negedge clk);
    rd_full(v); chk("R6 gate open", v, 2);
  endtask

  task automatic t_dec();
    int v;
    aux_func = 2; aux_sel = 1; acq();
    pulses(4'b0100, 4);
    pulse(4'b0010);
    rd_full(v); chk("R7 decrement", v, 3);
    pulse(4'b0110);
    rd_full(v); chk("R7 inc and dec cancel", v, 3);
    aux_func = 0;
  endtask

  task automatic t_snap();
    logic [3:0] d;
    acq();
    pulses(4'b0100, 37);
    rd(2'd0, d); chk("R8 live low word", d, 5);
    pulses(4'b0100, 16);
    rd(2'd1, d); chk("R8 high from snapshot", d, 2);
    rd(2'd0, d); chk("R8 new low word", d, 5);
    rd(2'd1, d); chk("R8 new snapshot high", d, 3);
  endtask

  task automatic t_clr();
    int v; logic [3:0] d;
    clr_on_read = 1;
    rd_stb = 1; rd_addr = 0; cnt_in[2] = 1;
    @(negedge clk);
    rd_stb = 0; cnt_in[2] = 0;
    d = rd_data;
    chk("R9 read returns pre-clear low", d, 5);
    @(negedge clk);
    rd(2'd0, d);
    chk("R9 clear plus edge gives 1", d, 1);
    clr_on_read = 0;
    rd_full(v); chk("R9 cleared without edge", v, 0);
  endtask

  task automatic t_roll();
    int v;
    wide_mode = 0; limit_mode = 0; acq();
    pulses(4'b0100, 17);
    rd_full(v); chk("R10 half-width wrap", v, 1);
    acq(); aux_func = 2; aux_sel = 1;
    pulse(4'b0010);
    rd_full(v); chk("R10 half-width dec from zero", v, 15);
    aux_func = 0; wide_mode = 1; acq();
    pulses(4'b0100, 255);
    rd_full(v); chk("R10 full-width max", v, 255);
    pulse(4'b0100);
    rd_full(v); chk("R10 full-width wrap", v, 0);
  endtask

  task automatic t_limit();
    int v;
    limit_mode = 1; wide_mode = 0; acq();
    pulses(4'b0100, 20);
    rd_full(v); chk("R11 half-width stop", v, 15);
    acq(); aux_func = 2; aux_sel = 1;
    pulse(4'b0010);
    rd_full(v); chk("R11 dec at zero holds", v, 0);
    aux_func = 0; wide_mode = 1; acq();
    pulses(4'b0100, 260);
    rd_full(v); chk("R11 full-width stop", v, 255);
    limit_mode = 0;
  endtask

  task automatic t_rdlat();
    rd_stb = 1; rd_addr = 0;
    @(posedge clk); #1;
    rd_stb = 0;
    chk("R12 data after one clock", rd_data, 15);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_count();
    t_acq();
    t_scan();
    t_latch();
    t_gate();
    t_dec();
    t_snap();
    t_clr();
    t_roll();
    t_limit();
    t_rdlat();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule